// File: doc/BRIEF.md
# Add/Subtract Arithmetic-Logic Unit with Status Flags

This unit performs the integer work of a small load/store processor's execute stage. Two 32-bit operands and a 3-bit operation code select one of five operations: addition, subtraction, bitwise AND, bitwise OR, and a signed less-than test. Addition and subtraction share one carry chain made of one-bit full adders. For subtraction the second operand is inverted bit by bit with XOR gates, and the same control sets the chain's initial carry.

Each result comes with three flags. The zero flag tells a branch unit whether two values are equal after a subtract. The carry flag is the carry out of the top bit. The overflow flag marks a signed result that does not fit in the word. Results and flags are captured in an output register, so they appear one clock after the operands are presented.

Top module: `alu_flags_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the unit clears `res`, `flag_carry` and `flag_ovf` to 0 and sets `flag_zero` to 1.
- R2: Operands and code sampled at a rising edge give their result and flags on the outputs right after that same edge. Back-to-back operations never mix.
- R3: Code 3'b000 (add) gives `res` = A + B modulo 2^32, and `flag_carry` is the carry out of bit 31.
- R4: Code 3'b001 (subtract) gives `res` = A - B modulo 2^32, computed as A + ~B + 1. `flag_carry` is the carry out of bit 31, which is 1 exactly when A >= B unsigned.
- R5: For add, subtract and less-than, `flag_ovf` is 1 exactly when the carry into bit 31 differs from the carry out of it. So an add of two operands of different sign never flags overflow.
- R6: Code 3'b010 gives A AND B, and code 3'b011 gives A OR B.
- R7: Code 3'b100 (less-than) gives `res` = 1 when A < B as signed two's-complement values and 0 otherwise. The test is the sign of A - B XOR its overflow. Carry and overflow report that subtraction.
- R8: `flag_zero` is 1 exactly when the 32-bit `res` is all zeros, for every code. A subtract of equal operands therefore sets it.
- R9: Codes 3'b101, 3'b110 and 3'b111 give `res` = 0, `flag_carry` = 0 and `flag_ovf` = 0.
- R10: For AND and OR, `flag_carry` and `flag_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select |
| res | output | 32 | Registered result |
| flag_zero | output | 1 | Registered all-zero indication of `res` |
| flag_carry | output | 1 | Registered carry out of the top bit |
| flag_ovf | output | 1 | Registered signed overflow |

## Verification
Zero, carry and overflow can all be raised by one operation. Adding 0x80000000 to itself wraps to zero, carries out of the top bit and overflows, all in the same cycle. The bench drives this case, a subtract of equal values (zero with carry set but no overflow), and a less-than whose difference overflows, where the overflow must reverse the sign test. Each is compared against a model of the whole output word and all three flags computed in the bench from 33-bit arithmetic. A long run of varied codes, with unused codes mixed in, is applied back to back so that a wrong select or a stale flag from the previous cycle shows up.

// File: rtl/alu_flags_pkg.sv
// Package: shared operation codes and widths for the add/subtract unit.
// Assumes the code field is 3 bits; codes above OP_SLT are unused.
package alu_flags_pkg;
    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_SLT = 3'b100
    } alu_op_e;
endpackage

// File: rtl/alu_bit_adder.sv
// One-bit full adder: sum and carry from two bits and an incoming carry.
// Assumes nothing beyond single-bit inputs; purely combinational.
module alu_bit_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    // sum and majority carry
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (x & cin) | (y & cin);
    end
endmodule

// File: rtl/alu_ripple_addsub.sv
// Ripple-carry adder/subtractor built from W one-bit adders.
// Each bit of y passes through an XOR with 'sub', and 'sub' also feeds the
// first carry, so sub=1 forms x + ~y + 1. Assumes W >= 2.
module alu_ripple_addsub #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         carry_into_msb
);
    logic [W:0]   chain;
    logic [W-1:0] y_cond;

    // conditional inversion of the second operand
    always_comb begin
        y_cond = y ^ {W{sub}};
    end

    assign chain[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        alu_bit_adder u_fa (
            .x    (x[i]),
            .y    (y_cond[i]),
            .cin  (chain[i]),
            .s    (sum[i]),
            .cout (chain[i+1])
        );
    end

    // carries at the sign position
    always_comb begin
        carry_out      = chain[W];
        carry_into_msb = chain[W-1];
    end
endmodule

// File: rtl/alu_bitwise.sv
// Bitwise AND / OR of two words; 'pick_or' selects OR.
// Assumes the caller gates the output for codes that do not use it.
module alu_bitwise #(
    parameter int W = 32
) (
    input  logic         pick_or,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] z
);
    // select between the two bitwise functions
    always_comb begin
        z = pick_or ? (x | y) : (x & y);
    end
endmodule

// File: rtl/alu_flags_unit.sv
// Top: add/subtract/AND/OR/signed less-than unit with zero, carry and
// overflow flags, all registered once. Assumes a single clock and a
// synchronous active-low reset; unused codes yield a zero result.
module alu_flags_unit #(
    parameter int W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [W-1:0]                  op_a,
    input  logic [W-1:0]                  op_b,
    input  logic [alu_flags_pkg::OPW-1:0] op_code,
    output logic [W-1:0]                  res,
    output logic                          flag_zero,
    output logic                          flag_carry,
    output logic                          flag_ovf
);
    import alu_flags_pkg::*;

    localparam int MSB = W - 1;

    logic         do_sub;
    logic [W-1:0] arith_sum;
    logic         arith_cout;
    logic         arith_cmsb;
    logic         arith_ovf;
    logic [W-1:0] logic_out;
    logic [W-1:0] res_d;
    logic         carry_d;
    logic         ovf_d;

    // subtract path serves both subtract and the less-than test
    always_comb begin
        do_sub = (op_code == OP_SUB) || (op_code == OP_SLT);
    end

    alu_ripple_addsub #(.W(W)) u_addsub (
        .sub            (do_sub),
        .x              (op_a),
        .y              (op_b),
        .sum            (arith_sum),
        .carry_out      (arith_cout),
        .carry_into_msb (arith_cmsb)
    );

    alu_bitwise #(.W(W)) u_bitwise (
        .pick_or (op_code == OP_OR),
        .x       (op_a),
        .y       (op_b),
        .z       (logic_out)
    );

    // signed overflow from disagreeing carries at the sign bit
    always_comb begin
        arith_ovf = arith_cmsb ^ arith_cout;
    end

    // result and flag selection by operation code
    always_comb begin
        res_d   = '0;
        carry_d = 1'b0;
        ovf_d   = 1'b0;
        case (op_code)
            OP_ADD, OP_SUB: begin
                res_d   = arith_sum;
                carry_d = arith_cout;
                ovf_d   = arith_ovf;
            end
            OP_AND, OP_OR: begin
                res_d = logic_out;
            end
            OP_SLT: begin
                res_d   = {{(W-1){1'b0}}, arith_sum[MSB] ^ arith_ovf};
                carry_d = arith_cout;
                ovf_d   = arith_ovf;
            end
            default: begin
                res_d = '0;
            end
        endcase
    end

    // output register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res        <= '0;
            flag_zero  <= 1'b1;
            flag_carry <= 1'b0;
            flag_ovf   <= 1'b0;
        end else begin
            res        <= res_d;
            flag_zero  <= (res_d == '0);
            flag_carry <= carry_d;
            flag_ovf   <= ovf_d;
        end
    end
endmodule

// File: rtl/alu_flags_unit_chk.sv
// Checker for alu_flags_unit: relates registered outputs to the inputs of
// the previous cycle. Assumes it is bound to every instance of the top.
module alu_flags_unit_chk #(
    parameter int W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [W-1:0]                  op_a,
    input logic [W-1:0]                  op_b,
    input logic [alu_flags_pkg::OPW-1:0] op_code,
    input logic [W-1:0]                  res,
    input logic                          flag_zero,
    input logic                          flag_carry,
    input logic                          flag_ovf
);
    import alu_flags_pkg::*;

    a_r8_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero == (res == '0));

    a_r7_slt_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_SLT) |-> (res[W-1:1] == '0));

    a_r9_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) > 3'd4) |->
        (res == '0 && !flag_carry && !flag_ovf));

    a_r10_logic_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_code) == OP_AND || $past(op_code) == OP_OR))
        |-> (!flag_carry && !flag_ovf));

    a_r5_mixed_sign_add: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_ADD &&
         $past(op_a[W-1]) != $past(op_b[W-1])) |-> !flag_ovf);

    a_r3_add_low_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OP_ADD) |->
        (res[0] == ($past(op_a[0]) ^ $past(op_b[0]))));
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_code    (op_code),
    .res        (res),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .flag_ovf   (flag_ovf)
);

// File: tb/alu_flags_unit_bench.sv
// Scoreboard bench: the driver queues expected outputs, the monitor pops
// and compares one clock later.
module alu_flags_unit_bench;
    localparam int W = 32;

    typedef struct {
        logic [W-1:0] r;
        logic         z;
        logic         c;
        logic         v;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   op_code = '0;
    logic [W-1:0] res;
    logic         flag_zero, flag_carry, flag_ovf;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    alu_flags_unit #(.W(W)) u_alu_flags_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .res(res), .flag_zero(flag_zero), .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    // independent model from 33-bit arithmetic
    function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, string tag);
        exp_t e;
        logic [W:0] wide;
        e.r = '0; e.c = 1'b0; e.v = 1'b0; e.tag = tag;
        case (op)
            3'd0: begin
                wide = {1'b0, a} + {1'b0, b};
                e.r = wide[W-1:0]; e.c = wide[W];
                e.v = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
            end
            3'd1, 3'd4: begin
                wide = {1'b0, a} + {1'b0, ~b} + 1;
                e.c = wide[W];
                e.v = (a[W-1] != b[W-1]) && (wide[W-1] != a[W-1]);
                e.r = (op == 3'd1) ? wide[W-1:0] : {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            end
            3'd2: e.r = a & b;
            3'd3: e.r = a | b;
            default: e.r = '0;
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] op, string tag);
        @(negedge clk);
        op_a = a; op_b = b; op_code = op;
        sb.push_back(model(a, b, op, tag));
    endtask

    task automatic check_out(exp_t e);
        n_checks++;
        if (res !== e.r || flag_zero !== e.z || flag_carry !== e.c || flag_ovf !== e.v) begin
            n_fail++;
            $display("FAIL %s: got res=%h z=%b c=%b v=%b, expected res=%h z=%b c=%b v=%b",
                     e.tag, res, flag_zero, flag_carry, flag_ovf, e.r, e.z, e.c, e.v);
        end
    endtask

    // monitor: compare each queued item right after the capturing edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) check_out(sb.pop_front());
    end

    task automatic check_reset(string tag);
        exp_t e;
        e.r = '0; e.z = 1'b1; e.c = 1'b0; e.v = 1'b0; e.tag = tag;
        check_out(e);
    endtask

    initial begin
        // R1: reset state with busy inputs
        op_a = 32'hFFFF_FFFF; op_b = 32'h1; op_code = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R1 reset state");
        rst_n = 1'b1;

        drive(32'd1, 32'd2, 3'd0, "R3 add small");
        drive(32'hFFFF_FFFF, 32'd1, 3'd0, "R3 R8 add wrap carry zero");
        drive(32'h7FFF_FFFF, 32'd1, 3'd0, "R5 add positive overflow");
        drive(32'h8000_0000, 32'h8000_0000, 3'd0, "R5 R8 zero carry overflow same cycle");
        drive(32'hFFFF_FFFF, 32'h0000_0001, 3'd0, "R5 mixed sign no overflow");
        drive(32'd5, 32'd5, 3'd1, "R4 R8 equal subtract");
        drive(32'd3, 32'd5, 3'd1, "R4 borrow");
        drive(32'h8000_0000, 32'd1, 3'd1, "R5 subtract overflow");
        drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd2, "R6 R10 and");
        drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'd3, "R6 R10 or");
        drive(32'h0F0F_0000, 32'hF0F0_0000, 3'd2, "R8 R10 and to zero");
        drive(32'hFFFF_FFFF, 32'd1, 3'd4, "R7 minus one below one");
        drive(32'd1, 32'hFFFF_FFFF, 3'd4, "R7 one not below minus one");
        drive(32'h8000_0000, 32'd1, 3'd4, "R7 overflowing difference");
        drive(32'h7FFF_FFFF, 32'h8000_0000, 3'd4, "R7 max not below min");
        drive(32'd9, 32'd9, 3'd4, "R7 equal gives zero");
        drive(32'hDEAD_BEEF, 32'h8000_0000, 3'd5, "R9 code 5");
        drive(32'h8000_0000, 32'h8000_0000, 3'd6, "R9 code 6");
        drive(32'hFFFF_FFFF, 32'h1, 3'd7, "R9 code 7");

        // R2: back-to-back varied traffic
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] ra, rb;
            logic [2:0] ro;
            ra = $urandom; rb = (i % 7 == 0) ? ra : $urandom;
            ro = 3'($urandom_range(0, 7));
            drive(ra, rb, ro, "R2 back-to-back");
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("R1 reset after traffic");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule